// File: doc/BRIEF.md
# Half-Bridge Gate Drive Controller

This block sequences the two gate enables of a synchronous buck output stage from a single pulse-width command. Two comparators in front of the block split the command into three levels: above the high threshold, below the low threshold, or stuck between them. A valid high level selects the upper switch and a valid low level selects the lower switch. Each hand-over between the switches passes through a fixed number of clock cycles in which neither gate is enabled.

A command that stays in the middle band for a programmable number of cycles is treated as a released input, and both switches are turned off. Switching resumes only after the command has been valid for the same number of cycles. Several conditions remove both gates on the next clock edge: a supply below its lockout level, a latched over-temperature condition, or a low external disable. The upper gate is also qualified by a bootstrap-charge latch with hysteresis.

The block drives two more outputs. One is a pull-down enable for an open-drain power-ready line. The other is an enable for an auxiliary supply, which a downstream controller can use as its own start signal.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With `pwm_above_hi`=1 and `pwm_below_lo`=0 the block settles with `gate_hi`=1 and `gate_lo`=0. With `pwm_below_lo`=1 and `pwm_above_hi`=0 it settles with `gate_lo`=1 and `gate_hi`=0.
- R2: `gate_hi` and `gate_lo` are never 1 together. When the command changes sides, the active gate drops on the first clock edge that sees the new command. The other gate rises exactly DEAD_CYC edges after that.
- R3: A mid-band command is any input with both comparator bits equal. While the command is mid-band, the last valid side is held. If the command is mid-band on TRI_DLY consecutive edges, both gates are off after the TRI_DLY-th edge. A shorter mid-band run causes no change at the gates.
- R4: After a mid-band timeout, the gates stay off until TRI_DLY consecutive valid edges have occurred. The selected gate then rises DEAD_CYC edges after the edge that ends the timeout, which is TRI_DLY+DEAD_CYC edges after the first valid one.
- R5: While `supply_good`=0, `prdy_pull_low` is 1 and `aux_en` is 0, both without delay. Both gates are off after the next clock edge.
- R6: When `supply_good`=1 and `overtemp`=1, both gates are off after the next edge. They stay off after `overtemp` returns to 0, until `temp_cool`=1 is seen. An `overtemp` pulse while `supply_good`=0 is not remembered.
- R7: `dis_n`=0 removes both gates after the next edge and drives `aux_en` to 0 without delay. It leaves `prdy_pull_low` unchanged.
- R8: `aux_en` equals `supply_good` AND `dis_n`, and is never 1 while `prdy_pull_low` is 1.
- R9: The upper gate may rise only once `boot_on_ok`=1 has been seen since `boot_off_ok` was last 0. It falls on the edge where `boot_off_ok`=0 is sampled. Once armed, the latch holds after `boot_on_ok` returns to 0.
- R10: During reset both gates are 0. After reset the first gate rises no earlier than DEAD_CYC edges later.
- R11: After any fault or timeout clears, a gate rises only after at least DEAD_CYC consecutive cycles with both gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_hi | input | 1 | PWM command above the high threshold |
| pwm_below_lo | input | 1 | PWM command below the low threshold |
| supply_good | input | 1 | Control supply above lockout level |
| overtemp | input | 1 | Die above the upper thermal trip |
| temp_cool | input | 1 | Die below the lower thermal trip |
| dis_n | input | 1 | External disable, active low |
| boot_on_ok | input | 1 | Bootstrap voltage above the arm threshold |
| boot_off_ok | input | 1 | Bootstrap voltage above the release threshold |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |
| prdy_pull_low | output | 1 | Pull-down enable of the open-drain power-ready line |
| aux_en | output | 1 | Auxiliary supply enable |

## Verification
Most internal faults show up at the gate pins within a few cycles. A sequencer counter that is off by one changes the count of both-off cycles between hand-overs, and the bench measures that count on every rising gate edge. A timeout counter in the mid-band filter that is wrong moves the edge at which the gates drop, or the edge at which they come back. The bench samples both edges at their exact cycle. A thermal or bootstrap latch that is stuck shows as a gate that stays on when it should drop, or as a gate that never returns after the clearing flag.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
   typedef enum logic [1:0] {
      LVL_MID  = 2'd0,
      LVL_HIGH = 2'd1,
      LVL_LOW  = 2'd2
   } pwm_lvl_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HIGH = 2'd1,
      SEQ_LOW  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/hb_mid_filter.sv
module hb_mid_filter
   import hb_gate_pkg::*;
#(
   parameter int TRI_DLY = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pwm_lvl_t lvl,
   output logic     tri_off,
   output logic     cmd_hi
);
   localparam int TW = (TRI_DLY > 1) ? $clog2(TRI_DLY) : 1;
   localparam logic [TW-1:0] LAST = TW'(TRI_DLY - 1);

   logic          tri_q;
   logic          cmd_q;
   logic [TW-1:0] cnt;
   logic          mid;

   assign mid     = (lvl == LVL_MID);
   assign tri_off = tri_q | (mid & (cnt == LAST));
   assign cmd_hi  = mid ? cmd_q : (lvl == LVL_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tri_q <= 1'b0;
         cmd_q <= 1'b0;
         cnt   <= '0;
      end else begin
         if (!mid) cmd_q <= (lvl == LVL_HIGH);
         if (tri_q) begin
            if (mid) cnt <= '0;
            else if (cnt == LAST) begin
               tri_q <= 1'b0;
               cnt   <= '0;
            end else cnt <= cnt + 1'b1;
         end else begin
            if (!mid) cnt <= '0;
            else if (cnt == LAST) begin
               tri_q <= 1'b1;
               cnt   <= '0;
            end else cnt <= cnt + 1'b1;
         end
      end
   end

   assert_tri_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tri_q) |-> $past(mid));
   assert_tri_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tri_q) |-> !$past(mid));
endmodule

// File: rtl/hb_boot_latch.sv
module hb_boot_latch #(
   parameter bit BOOT_GATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_on_ok,
   input  logic boot_off_ok,
   output logic boot_ok
);
   if (BOOT_GATE) begin : g_latch
      logic rdy_q;
      assign boot_ok = (rdy_q | boot_on_ok) & boot_off_ok;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdy_q <= 1'b0;
         else        rdy_q <= boot_ok;
      end
      assert_boot_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !boot_off_ok |=> !rdy_q);
   end else begin : g_bypass
      assign boot_ok = 1'b1;
   end
endmodule

// File: rtl/hb_dead_seq.sv
module hb_dead_seq
   import hb_gate_pkg::*;
#(
   parameter int DEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic want_hi,
   input  logic want_lo,
   output logic gate_hi,
   output logic gate_lo
);
   localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
   localparam logic [DW-1:0] LAST = DW'(DEAD_CYC - 1);

   seq_state_t    state;
   logic [DW-1:0] cnt;

   assign gate_hi = (state == SEQ_HIGH);
   assign gate_lo = (state == SEQ_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            SEQ_HIGH: if (kill || !want_hi) begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
            SEQ_LOW: if (kill || !want_lo) begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
            default: begin
               if (kill) cnt <= '0;
               else if (cnt == LAST && want_hi) state <= SEQ_HIGH;
               else if (cnt == LAST && want_lo) state <= SEQ_LOW;
               else if (cnt != LAST) cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   assert_kill_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (state == SEQ_IDLE));
   assert_no_direct_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_IDLE) |=> (state == $past(state) || state == SEQ_IDLE));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
   import hb_gate_pkg::*;
#(
   parameter int DEAD_CYC  = 4,
   parameter int TRI_DLY   = 16,
   parameter bit BOOT_GATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_above_hi,
   input  logic pwm_below_lo,
   input  logic supply_good,
   input  logic overtemp,
   input  logic temp_cool,
   input  logic dis_n,
   input  logic boot_on_ok,
   input  logic boot_off_ok,
   output logic gate_hi,
   output logic gate_lo,
   output logic prdy_pull_low,
   output logic aux_en
);
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (TRI_DLY < 1) begin : g_bad_tri
      $error("TRI_DLY must be at least 1");
   end

   pwm_lvl_t lvl;
   logic     tri_off, cmd_hi, boot_ok, ot_q, kill;

   always_comb begin
      if (pwm_above_hi && !pwm_below_lo)      lvl = LVL_HIGH;
      else if (pwm_below_lo && !pwm_above_hi) lvl = LVL_LOW;
      else                                    lvl = LVL_MID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ot_q <= 1'b0;
      else if (!supply_good)           ot_q <= 1'b0;
      else if (overtemp)               ot_q <= 1'b1;
      else if (temp_cool)              ot_q <= 1'b0;
   end

   assign kill = !supply_good | !dis_n | tri_off | (supply_good & (ot_q | overtemp));
   assign prdy_pull_low = !supply_good;
   assign aux_en        = supply_good & dis_n;

   hb_mid_filter #(.TRI_DLY(TRI_DLY)) u_mid (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .tri_off(tri_off), .cmd_hi(cmd_hi));

   hb_boot_latch #(.BOOT_GATE(BOOT_GATE)) u_boot (
      .clk(clk), .rst_n(rst_n), .boot_on_ok(boot_on_ok),
      .boot_off_ok(boot_off_ok), .boot_ok(boot_ok));

   hb_dead_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .kill(kill),
      .want_hi(cmd_hi & boot_ok), .want_lo(!cmd_hi),
      .gate_hi(gate_hi), .gate_lo(gate_lo));

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));
   assert_uv_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_good |=> (!gate_hi && !gate_lo));
   assert_ot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_good && overtemp) |=> (!gate_hi && !gate_lo));
   assert_dis_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dis_n |=> (!gate_hi && !gate_lo));
   assert_aux_vs_prdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en |-> !prdy_pull_low);
endmodule

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;
   localparam int DEAD = 4;
   localparam int TRI  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic above = 1'b0, below = 1'b1, sg = 1'b1, ot = 1'b0, cool = 1'b1;
   logic dis_n = 1'b1, bon = 1'b1, boff = 1'b1;
   logic gate_hi, gate_lo, prdy_pull_low, aux_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hb_gate_ctrl #(.DEAD_CYC(DEAD), .TRI_DLY(TRI), .BOOT_GATE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .pwm_above_hi(above), .pwm_below_lo(below),
      .supply_good(sg), .overtemp(ot), .temp_cool(cool), .dis_n(dis_n),
      .boot_on_ok(bon), .boot_off_ok(boff), .gate_hi(gate_hi), .gate_lo(gate_lo),
      .prdy_pull_low(prdy_pull_low), .aux_en(aux_en));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_gates(input string req, input string what,
                            input logic eh, input logic el);
      chk(gate_hi == eh && gate_lo == el, req, what,
          {gate_hi, gate_lo}, {eh, el});
   endtask

   // waits at negedges until the named gate is on; one check
   task automatic wait_on(input bit hi_side, input int lim, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < lim && !seen; i++) begin
         @(negedge clk);
         seen = hi_side ? gate_hi : gate_lo;
      end
      chk(seen, req, hi_side ? "upper gate returns" : "lower gate returns",
          seen, 1);
   endtask

   // monitor: overlap and both-off run before every rising gate (R2, R11)
   int off_run = 100;
   always @(negedge clk) begin
      if (rst_n) begin
         if (gate_hi && gate_lo) chk(1'b0, "R2", "both gates on", 1, 0);
         if (!gate_hi && !gate_lo) off_run++;
         else begin
            if (off_run > 0)
               chk(off_run >= DEAD, "R11", "off cycles before rise", off_run, DEAD);
            off_run = 0;
         end
      end else off_run = 0;
   end

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_gates("R10", "gates in reset", 1'b0, 1'b0);
      chk(prdy_pull_low == 1'b0 && aux_en == 1'b1, "R8", "flags in reset",
          {prdy_pull_low, aux_en}, 2'b01);
      rst_n = 1'b1;
      repeat (DEAD - 1) @(negedge clk);
      chk_gates("R10", "still off before dead time", 1'b0, 1'b0);
      wait_on(1'b0, 4, "R1");
   endtask

   task automatic t_swap();
      above = 1'b1; below = 1'b0;
      @(negedge clk);
      chk_gates("R2", "lower drops on first edge", 1'b0, 1'b0);
      repeat (DEAD - 1) @(negedge clk);
      chk_gates("R2", "still dead before high", 1'b0, 1'b0);
      @(negedge clk);
      chk_gates("R1", "upper on after dead time", 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      above = 1'b0; below = 1'b1;
      @(negedge clk);
      chk_gates("R2", "upper drops on first edge", 1'b0, 1'b0);
      repeat (DEAD - 1) @(negedge clk);
      chk_gates("R2", "still dead before low", 1'b0, 1'b0);
      @(negedge clk);
      chk_gates("R1", "lower on after dead time", 1'b0, 1'b1);
   endtask

   task automatic t_mid_short();
      int drops = 0;
      above = 1'b1; below = 1'b1;
      for (int i = 0; i < TRI - 1; i++) begin
         @(negedge clk);
         if (!gate_lo) drops++;
      end
      above = 1'b0; below = 1'b1;
      for (int i = 0; i < TRI + 2; i++) begin
         @(negedge clk);
         if (!gate_lo) drops++;
      end
      chk(drops == 0, "R3", "short mid run keeps lower gate", drops, 0);
   endtask

   task automatic t_mid_timeout();
      above = 1'b1; below = 1'b0;
      wait_on(1'b1, DEAD + 3, "R1");
      above = 1'b0; below = 1'b0;
      repeat (TRI - 1) @(negedge clk);
      chk_gates("R3", "held command before timeout", 1'b1, 1'b0);
      @(negedge clk);
      chk_gates("R3", "off at timeout", 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      above = 1'b1;
      repeat (TRI + DEAD - 1) @(negedge clk);
      chk_gates("R4", "off until release plus dead", 1'b0, 1'b0);
      @(negedge clk);
      chk_gates("R4", "upper back after release", 1'b1, 1'b0);
   endtask

   task automatic t_uv();
      above = 1'b0; below = 1'b1;
      wait_on(1'b0, DEAD + 3, "R1");
      sg = 1'b0;
      #1;
      chk(prdy_pull_low == 1'b1 && aux_en == 1'b0, "R5", "flags under lockout",
          {prdy_pull_low, aux_en}, 2'b10);
      @(negedge clk);
      chk_gates("R5", "gates off under lockout", 1'b0, 1'b0);
      ot = 1'b1; cool = 1'b0;
      repeat (2) @(negedge clk);
      ot = 1'b0;
      @(negedge clk);
      sg = 1'b1;
      wait_on(1'b0, DEAD + 3, "R6");
      cool = 1'b1;
   endtask

   task automatic t_ot();
      ot = 1'b1; cool = 1'b0;
      @(negedge clk);
      chk_gates("R6", "off on overtemp", 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      ot = 1'b0;
      repeat (12) @(negedge clk);
      chk_gates("R6", "latched off until cool", 1'b0, 1'b0);
      cool = 1'b1;
      wait_on(1'b0, DEAD + 3, "R6");
   endtask

   task automatic t_dis();
      dis_n = 1'b0;
      #1;
      chk(aux_en == 1'b0 && prdy_pull_low == 1'b0, "R7", "aux off, ready kept",
          {aux_en, prdy_pull_low}, 2'b00);
      @(negedge clk);
      chk_gates("R7", "gates off on disable", 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      dis_n = 1'b1;
      #1;
      chk(aux_en == 1'b1, "R8", "aux back on", aux_en, 1);
      wait_on(1'b0, DEAD + 3, "R11");
   endtask

   task automatic t_boot();
      boff = 1'b0; bon = 1'b0;
      @(negedge clk);
      boff = 1'b1;
      above = 1'b1; below = 1'b0;
      repeat (3 * DEAD) @(negedge clk);
      chk_gates("R9", "upper blocked without arm", 1'b0, 1'b0);
      bon = 1'b1;
      @(negedge clk);
      bon = 1'b0;
      wait_on(1'b1, DEAD + 3, "R9");
      repeat (10) @(negedge clk);
      chk_gates("R9", "armed latch holds", 1'b1, 1'b0);
      boff = 1'b0;
      @(negedge clk);
      chk_gates("R9", "upper drops on release flag", 1'b0, 1'b0);
      boff = 1'b1;
      repeat (10) @(negedge clk);
      chk_gates("R9", "stays off until re-armed", 1'b0, 1'b0);
      bon = 1'b1;
      wait_on(1'b1, DEAD + 3, "R9");
      above = 1'b0; below = 1'b1;
      wait_on(1'b0, DEAD + 3, "R1");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_swap();
      t_mid_short();
      t_mid_timeout();
      t_uv();
      t_ot();
      t_dis();
      t_boot();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule